// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Interrupt Requests

This block turns parallel bytes into an asynchronous serial stream. It has two stages. A one-entry holding register takes each write from the bus. A shift register sends the frames on the line. When the shifter finishes a frame and the holding register is full, the held byte moves across on that same bit boundary. Frames therefore follow each other with no idle bit between them. Bit timing comes from a one-cycle `baud_tick` enable, and every bit lasts exactly one tick period.

An interrupt request becomes pending on either of two events, provided `irq_en` is high:
- the holding register is drained into the shifter;
- the whole transmitter goes idle.

Software refills the holding register by writing to it, and that write also clears the request. When software has no more data, it clears the request with a dummy status write, which changes nothing else. The later idle request is the signal that the last stop bit has left the line.

The shifter is a state machine with five states:
- `TX_IDLE`: line high, shifter empty.
- `TX_START`: the start bit is on the line.
- `TX_DATA`: the data bits are on the line.
- `TX_ADDR`: the optional address bit is on the line.
- `TX_STOP`: the stop bit is on the line.

Its transitions, each taken on a tick, are:
- `IDLE→START`: taken when the holding register is full (this is a load).
- `START→DATA`.
- `DATA→ADDR` or `DATA→STOP`: taken after the last data bit.
- `ADDR→STOP`.
- `STOP→START`: back-to-back, taken when the holding register is full (this is a load).
- `STOP→IDLE`: taken when the holding register is empty; this is the idle event.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `tx` is 1, `stat_hold_empty` is 1, `stat_idle` is 1 and `irq` is 0.
- R2: A frame consists of:
  - a start bit of 0;
  - the data bits, least significant bit first;
  - when the address option is on, an address bit driven to 0;
  - a stop bit of 1.

  Each bit lasts one `baud_tick` period, and the line rests at 1 between frames.
- R3: `cfg_seven`=1 sends 7 data bits and 0 sends 8. A frame lasts 9, 10 or 11 bit periods. `cfg_seven` and `cfg_addr` are sampled when the byte is loaded into the shifter.
- R4: If the holding register is full when a stop bit ends, the next start bit begins immediately, with no idle bit between the frames.
- R5: A load from holding to shifter that is not accompanied by a data write in the same cycle makes `irq` pending from the next cycle, if `irq_en` is 1.
- R6: If the holding register is empty when a stop bit ends, `irq` becomes pending from the next cycle, if `irq_en` is 1.
- R7: A pending `irq` is cleared by `wr_data` or by `wr_stat`. If a set event and a clear fall in the same cycle, the set wins and `irq` stays 1.
- R8: `wr_stat` leaves the holding register contents and both status flags unchanged.
- R9: While `irq_en` is 0, no event makes `irq` pending.
- R10: A data write while the holding register is full replaces the held byte. Only the last byte written is transmitted.
- R11: If a data write falls in the same cycle as a load, the shifter takes the previously held byte. The new byte stays held, and no holding-empty request arises.
- R12: `stat_hold_empty` is 1 exactly when the holding register is empty. `stat_idle` is 1 exactly when the shifter is in `TX_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle bit-period enable |
| cfg_seven | input | 1 | 1: seven data bits, 0: eight |
| cfg_addr | input | 1 | Append address bit (driven 0) |
| irq_en | input | 1 | Allow interrupt events to set the request |
| wr_data | input | 1 | Write strobe for the holding register |
| wr_stat | input | 1 | Dummy status write, clears the request |
| wdata | input | DATA_W | Byte to transmit |
| stat_hold_empty | output | 1 | Holding register empty |
| stat_idle | output | 1 | Shifter idle |
| irq | output | 1 | Pending interrupt request |
| tx | output | 1 | Serial line |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a data write and a load from holding to shifter. The bench provokes it by placing the write strobe in the exact tick cycle on which the shifter pulls a waiting byte. The bench expects the old byte on the line, the new byte still held, and no request raised.

The second pair is a clear and a set of the request. The bench places a status write on the tick that ends the last stop bit, and it expects the request to be pending afterwards.

A behavioural model, built on a queue of line bits, is compared with `tx`, `irq` and both flags on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_ADDR,
        TX_STOP
    } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty_evt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (wr_en) begin
            hold_full <= 1'b1;
            hold_data <= wdata;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    // The register only drains when no new byte arrives in the same cycle.
    assign empty_evt = load & ~wr_en;

    // R11
    write_wins_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wr_en) |=> hold_full);

    // R10
    overwrite_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (hold_data == $past(wdata)));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cfg_seven,
    input  logic              cfg_addr,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              load,
    output logic              idle_evt,
    output logic              busy,
    output logic              tx
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic              seven_q;
    logic              addr_q;
    logic [CNT_W-1:0]  last_idx;

    assign last_idx = seven_q ? CNT_W'(DATA_W - 2) : CNT_W'(DATA_W - 1);

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        idle_evt = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (baud_tick && hold_full) begin
                    load    = 1'b1;
                    state_d = TX_START;
                end
            end
            TX_START: begin
                if (baud_tick) state_d = TX_DATA;
            end
            TX_DATA: begin
                if (baud_tick && (cnt_q == last_idx))
                    state_d = addr_q ? TX_ADDR : TX_STOP;
            end
            TX_ADDR: begin
                if (baud_tick) state_d = TX_STOP;
            end
            TX_STOP: begin
                if (baud_tick) begin
                    if (hold_full) begin
                        load    = 1'b1;
                        state_d = TX_START;
                    end else begin
                        idle_evt = 1'b1;
                        state_d  = TX_IDLE;
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            seven_q <= 1'b0;
            addr_q  <= 1'b0;
        end else if (load) begin
            sh_q    <= hold_data;
            cnt_q   <= '0;
            seven_q <= cfg_seven;
            addr_q  <= cfg_addr;
        end else if ((state_q == TX_DATA) && baud_tick) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            TX_IDLE:  tx = 1'b1;
            TX_START: tx = 1'b0;
            TX_DATA:  tx = sh_q[0];
            TX_ADDR:  tx = 1'b0;
            TX_STOP:  tx = 1'b1;
            default:  tx = 1'b1;
        endcase
    end
    assign busy = (state_q != TX_IDLE);

    // R4
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_STOP && baud_tick && hold_full) |=> (state_q == TX_START));

    // R3
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA) |-> (cnt_q <= last_idx));

    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && state_q != TX_IDLE) |=> $stable(state_q));
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic hold_evt,
    input  logic idle_evt,
    input  logic wr_data,
    input  logic wr_stat,
    output logic irq
);
    logic set_req;
    logic clr_req;

    assign set_req = irq_en & (hold_evt | idle_evt);
    assign clr_req = wr_data | wr_stat;

    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (set_req) irq <= 1'b1;
        else if (clr_req) irq <= 1'b0;
    end

    // R7
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_data || wr_stat) && !(irq_en && (hold_evt || idle_evt))) |=> !irq);

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !irq) |=> !irq);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cfg_seven,
    input  logic              cfg_addr,
    input  logic              irq_en,
    input  logic              wr_data,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    output logic              stat_hold_empty,
    output logic              stat_idle,
    output logic              irq,
    output logic              tx
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              hold_evt;
    logic              idle_evt;
    logic              busy;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_data),
        .wdata     (wdata),
        .load      (load),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .empty_evt (hold_evt)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .cfg_seven (cfg_seven),
        .cfg_addr  (cfg_addr),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .load      (load),
        .idle_evt  (idle_evt),
        .busy      (busy),
        .tx        (tx)
    );

    uart_tx_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_en   (irq_en),
        .hold_evt (hold_evt),
        .idle_evt (idle_evt),
        .wr_data  (wr_data),
        .wr_stat  (wr_stat),
        .irq      (irq)
    );

    assign stat_hold_empty = ~hold_full;
    assign stat_idle       = ~busy;

    // R8
    stat_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wr_data && !load) |=> $stable(stat_hold_empty));

    // R6
    idle_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && idle_evt) |=> (irq && stat_idle));
endmodule

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;
    localparam int CLK_P    = 10;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_on = 1'b1;
    logic       baud_tick;
    logic       cfg_seven = 1'b0;
    logic       cfg_addr = 1'b0;
    logic       irq_en = 1'b1;
    logic       wr_data = 1'b0;
    logic       wr_stat = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       stat_hold_empty, stat_idle, irq, tx;

    int    n_chk = 0;
    int    n_fail = 0;
    int    tdiv = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #(CLK_P/2) clk = ~clk;

    uart_tx_dbuf #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_seven(cfg_seven), .cfg_addr(cfg_addr), .irq_en(irq_en),
        .wr_data(wr_data), .wr_stat(wr_stat), .wdata(wdata),
        .stat_hold_empty(stat_hold_empty), .stat_idle(stat_idle),
        .irq(irq), .tx(tx)
    );

    always @(negedge clk) tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    assign baud_tick = tick_on && (tdiv == TICK_DIV-1);

    // Behavioural reference: queue of line bits still to send
    bit       mq[$];
    bit       m_full;
    bit [7:0] m_val;
    bit       m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_full = 0; m_val = 0; m_irq = 0;
        end else begin
            bit ld, iev, setv;
            ld = 0; iev = 0;
            if (baud_tick) begin
                if (mq.size() != 0) begin
                    void'(mq.pop_front());
                    if (mq.size() == 0) begin
                        if (m_full) ld = 1; else iev = 1;
                    end
                end else if (m_full) ld = 1;
            end
            if (ld) begin
                mq.push_back(1'b0);
                for (int i = 0; i < (cfg_seven ? 7 : 8); i++) mq.push_back(m_val[i]);
                if (cfg_addr) mq.push_back(1'b0);
                mq.push_back(1'b1);
            end
            setv = irq_en && ((ld && !wr_data) || iev);
            if (setv) m_irq = 1;
            else if (wr_data || wr_stat) m_irq = 0;
            if (wr_data) begin m_full = 1; m_val = wdata; end
            else if (ld) m_full = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit etx;
            etx = (mq.size() != 0) ? mq[0] : 1'b1;
            check(tx == etx, cur_req, "tx", tx, etx);
            check(irq == m_irq, cur_req, "irq", irq, m_irq);
            // R12 flags against model
            check(stat_hold_empty == !m_full, "R12", "hold_empty", stat_hold_empty, !m_full);
            check(stat_idle == (mq.size() == 0), "R12", "idle", stat_idle, mq.size() == 0);
        end
    end

    task automatic step; @(negedge clk); #1; endtask

    task automatic put(input logic [7:0] v);
        step(); wr_data = 1; wdata = v;
        step(); wr_data = 0;
    endtask

    task automatic put_on_tick(input logic [7:0] v);
        step();
        while (tdiv != TICK_DIV-1) step();
        wr_data = 1; wdata = v;
        step(); wr_data = 0;
    endtask

    task automatic stat_write;
        step(); wr_stat = 1;
        step(); wr_stat = 0;
    endtask

    task automatic wait_quiet;
        step();
        while (!(stat_idle && stat_hold_empty)) step();
        step();
    endtask

    task automatic wait_irq;
        step();
        while (!irq) step();
    endtask

    task automatic measure(input int exp_cycles, input string req);
        int n;
        n = 0;
        while (stat_idle) step();
        while (!stat_idle) begin n++; step(); end
        check(n == exp_cycles, req, "frame cycles", n, exp_cycles);
    endtask

    task automatic finish_run;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) step();
        rst_n = 1;
        step();
        // R1 reset state
        check(tx == 1, "R1", "tx", tx, 1);
        check(stat_hold_empty == 1, "R1", "hold_empty", stat_hold_empty, 1);
        check(stat_idle == 1, "R1", "idle", stat_idle, 1);
        check(irq == 0, "R1", "irq", irq, 0);

        // R2 / R5 / R6: single 8-bit frame
        cur_req = "R2";
        put(8'hA5);
        wait_irq();
        cur_req = "R5";
        check(irq == 1, "R5", "irq after drain", irq, 1);
        stat_write();
        // R8 status write leaves flags alone
        check(stat_hold_empty == 1 && stat_idle == 0, "R8", "flags after stat write",
              {stat_hold_empty, stat_idle}, 2);
        cur_req = "R6";
        wait_irq();
        check(stat_idle == 1, "R6", "idle at idle irq", stat_idle, 1);
        stat_write();
        check(irq == 0, "R7", "irq after stat write", irq, 0);

        // R3: lengths of 9 and 11 bit periods
        cur_req = "R3";
        cfg_seven = 1; cfg_addr = 0;
        put(8'h3C);
        measure(9 * TICK_DIV, "R3");
        wait_quiet();
        cfg_seven = 0; cfg_addr = 1;
        put(8'hC3);
        measure(11 * TICK_DIV, "R3");
        wait_quiet();
        stat_write();

        // R4: back-to-back, refill on each holding-empty request
        cur_req = "R4";
        cfg_seven = 1; cfg_addr = 1;
        put(8'h11);
        for (int k = 0; k < 3; k++) begin
            wait_irq();
            put(8'h55 + 8'(k));
            check(irq == 0, "R7", "irq cleared by data write", irq, 0);
        end
        wait_quiet();
        stat_write();
        cfg_seven = 0; cfg_addr = 0;

        // R10: overwrite while held (ticks paused)
        cur_req = "R10";
        tick_on = 0;
        put(8'hF0);
        put(8'h0F);
        check(stat_hold_empty == 0, "R10", "held", stat_hold_empty, 0);
        tick_on = 1;
        wait_quiet();
        stat_write();

        // R9: interrupts disabled
        cur_req = "R9";
        irq_en = 0;
        put(8'h81);
        wait_quiet();
        check(irq == 0, "R9", "irq while disabled", irq, 0);
        irq_en = 1;

        // R11: data write in the load cycle
        cur_req = "R11";
        step();
        while (tdiv != 0) step();
        put(8'h96);
        put_on_tick(8'h69);
        check(stat_hold_empty == 0 && irq == 0, "R11", "held and quiet",
              {stat_hold_empty, irq}, 0);
        wait_quiet();
        stat_write();

        // R7: status write on the idle edge, set wins
        cur_req = "R7";
        put(8'h42);
        wait_irq();
        stat_write();
        step();
        while (!(tdiv == TICK_DIV-1 && mq.size() == 1)) step();
        wr_stat = 1;
        step(); wr_stat = 0;
        check(irq == 1, "R7", "set wins over clear", irq, 1);
        stat_write();
        repeat (3) step();
        finish_run();
    end
endmodule